// File: doc/BRIEF.md
# Octal Converter Code Register Front End

This block is the digital control side of an eight-channel voltage-output converter. A host drives a three-wire serial port: a serial clock, a serial data line and an active-low frame line. While the frame line is low, each rising serial-clock edge moves one data bit into a 16-bit shift register. When the frame line goes high, the block decodes the 4-bit address/control field at the top of the captured word. Depending on that field it writes one channel code register, writes all eight with the same value, writes nothing, or enters a low-power sleep state.

The serial inputs are asynchronous to the block's system clock. They pass through a synchronizer, and their edges are detected in the system clock domain. A buffered serial output repeats each input bit 16 serial-clock rising edges later, so several devices can be chained into one long shift register. An active-low wipe input clears the shift register, all channel registers and the sleep flag at once. The power-on reset leaves the same cleared state. The code width is a parameter; 8 and 10 bits are the intended values.

Top module: `octal_dac_front`

## Requirements
- R1: After power-on reset, all eight channel codes are zero, `asleep` is 0 and `ser_out` is 0.
- R2: While `frame_n` is low, each rising `ser_clk` edge shifts `ser_in` into the LSB of a 16-bit shift register. The word is sent MSB first. Bits 15..12 are the address, the next CODE_W bits are the code (MSB first), and the remaining low bits are ignored.
- R3: While `frame_n` is high, `ser_clk` edges neither change the shift register nor change `ser_out`.
- R4: On a rising `frame_n` with address 1..8, channel (address-1) takes the code, and every other channel keeps its value.
- R5: On a rising `frame_n` with address 15, all eight channels take the same code.
- R6: On a rising `frame_n` with address 0 or 9..13, no channel changes.
- R7: On a rising `frame_n` with address 14, `asleep` becomes 1, the code field is ignored and every channel keeps its value.
- R8: A rising `frame_n` with any address other than 14 sets `asleep` to 0. This includes the no-change addresses. The channel write for that address still takes place.
- R9: `ser_out` updates only on a falling `ser_clk` edge while `frame_n` is low. It then shows shift-register bit 15, so each input bit reappears after 16 rising edges.
- R10: Driving `wipe_n` low clears the shift register, all channel codes and `asleep` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wipe_n | input | 1 | Clear of shift and channel registers, active low |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_in | input | 1 | Serial data in |
| frame_n | input | 1 | Frame select, low to shift, rising edge loads |
| ser_out | output | 1 | Delayed serial data out for chaining |
| asleep | output | 1 | Sleep state flag |
| dac_codes | output | 8*CODE_W | Channel codes, channel 0 in the low bits |

## Verification
Each serial input edge passes two synchronizer flops and one edge-detect compare, so its effect lands on the third system-clock rising edge after the bench changes the pin. Shift-register moves, `ser_out` updates and channel loads all follow that rule. The bench drives pins on the falling clock edge and holds each serial level for four system cycles. It samples `ser_out` four cycles after every falling `ser_clk`, and it samples the channel codes and `asleep` six cycles after each rising `frame_n`. The clear is asynchronous, so its result is checked one cycle after `wipe_n` falls. The bench waits six cycles after release before it sends the next word.

// File: rtl/octal_dac_pkg.sv
package octal_dac_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int NUM_CH = 8;

  localparam logic [ADDR_W-1:0] ADR_FIRST_CH = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_LAST_CH  = 4'h8;
  localparam logic [ADDR_W-1:0] ADR_SLEEP    = 4'hE;
  localparam logic [ADDR_W-1:0] ADR_ALL      = 4'hF;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ONE   = 2'd1,
    ACT_ALL   = 2'd2,
    ACT_SLEEP = 2'd3
  } act_e;

  function automatic act_e decode_act(input logic [ADDR_W-1:0] a);
    act_e r;
    if (a == ADR_SLEEP)                          r = ACT_SLEEP;
    else if (a == ADR_ALL)                       r = ACT_ALL;
    else if (a >= ADR_FIRST_CH && a <= ADR_LAST_CH) r = ACT_ONE;
    else                                         r = ACT_NONE;
    return r;
  endfunction

endpackage

// File: rtl/dacs_rst_sync.sv
module dacs_rst_sync (
  input  logic clk,
  input  logic arst_in_n,
  output logic rst_out_n
);
  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb chain_d = {chain_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_in_n) begin
    if (!arst_in_n) chain_q <= 2'b00;
    else            chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[1];
endmodule

// File: rtl/dacs_sync.sv
module dacs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][WIDTH-1:0] pipe_q;
  logic [DEPTH-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = async_in;
    for (int s = 1; s < DEPTH; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {DEPTH{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign level = pipe_q[STAGES-1];
  assign rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/dacs_shift.sv
module dacs_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_lvl,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              ser_out
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              so_q, so_d;
  logic              shift_en, out_en;

  assign shift_en = sclk_rise & ~frame_lvl;
  assign out_en   = sclk_fall & ~frame_lvl;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[WORD_W-2:0], bit_in};
    so_d = so_q;
    if (out_en) so_d = sh_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      so_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      so_q <= so_d;
    end
  end

  assign word    = sh_q;
  assign ser_out = so_q;

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lvl |=> $stable(sh_q));

  // R9
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(so_q));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !frame_lvl) |=> (sh_q[0] == $past(bit_in)));
endmodule

// File: rtl/dacs_bank.sv
module dacs_bank
  import octal_dac_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_stb,
  input  logic [WORD_W-1:0]        word,
  output logic [NUM_CH*CODE_W-1:0] codes,
  output logic                     asleep
);
  localparam int CODE_MSB = WORD_W - ADDR_W - 1;
  localparam int PAD_W    = WORD_W - ADDR_W - CODE_W;

  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] code;
  act_e              act;
  logic [NUM_CH-1:0] wr_one;
  logic              wr_all;
  logic              sleep_q, sleep_d;
  logic [CODE_W-1:0] code_q [NUM_CH];

  assign addr   = word[WORD_W-1 -: ADDR_W];
  assign code   = word[CODE_MSB -: CODE_W];
  assign act    = decode_act(addr);
  assign wr_all = load_stb && (act == ACT_ALL);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CODE_W-1:0] cd;
      assign wr_one[i] = load_stb && (act == ACT_ONE) &&
                         (addr == ADDR_W'(i + 1));
      always_comb begin
        cd = code_q[i];
        if (wr_one[i] || wr_all) cd = code;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q[i] <= '0;
        else        code_q[i] <= cd;
      end
      assign codes[i*CODE_W +: CODE_W] = code_q[i];
    end
    if (PAD_W < 0) begin : g_bad_width
      logic unused_pad;
      assign unused_pad = 1'b0;
    end
  endgenerate

  always_comb begin
    sleep_d = sleep_q;
    if (load_stb) sleep_d = (act == ACT_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_d;
  end

  assign asleep = sleep_q;

  // R4
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_one));

  // R5
  all_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_all |=> (code_q[0] == code_q[NUM_CH-1]) && (code_q[0] == $past(code)));

  // R6
  nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && act == ACT_NONE) |=> $stable(codes));

  // R7
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && addr == ADR_SLEEP) |=> (sleep_q && $stable(codes)));

  // R8
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && addr != ADR_SLEEP) |=> !sleep_q);
endmodule

// File: rtl/octal_dac_front.sv
module octal_dac_front
  import octal_dac_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wipe_n,
  input  logic                     ser_clk,
  input  logic                     ser_in,
  input  logic                     frame_n,
  output logic                     ser_out,
  output logic                     asleep,
  output logic [NUM_CH*CODE_W-1:0] dac_codes
);
  localparam int PIN_N   = 3;
  localparam int P_DATA  = 0;
  localparam int P_SCLK  = 1;
  localparam int P_FRAME = 2;

  logic              por_rst_n, dat_rst_n, dat_arst_n;
  logic [PIN_N-1:0]  pins, pin_lvl, pin_rise, pin_fall;
  logic [WORD_W-1:0] word;

  assign dat_arst_n = rst_n & wipe_n;

  dacs_rst_sync i_por_rst (
    .clk       (clk),
    .arst_in_n (rst_n),
    .rst_out_n (por_rst_n)
  );

  dacs_rst_sync i_dat_rst (
    .clk       (clk),
    .arst_in_n (dat_arst_n),
    .rst_out_n (dat_rst_n)
  );

  assign pins = {frame_n, ser_clk, ser_in};

  dacs_sync #(
    .WIDTH   (PIN_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) i_sync (
    .clk      (clk),
    .rst_n    (por_rst_n),
    .async_in (pins),
    .level    (pin_lvl),
    .rise     (pin_rise),
    .fall     (pin_fall)
  );

  dacs_shift #(
    .WORD_W (WORD_W)
  ) i_shift (
    .clk       (clk),
    .rst_n     (dat_rst_n),
    .frame_lvl (pin_lvl[P_FRAME]),
    .sclk_rise (pin_rise[P_SCLK]),
    .sclk_fall (pin_fall[P_SCLK]),
    .bit_in    (pin_lvl[P_DATA]),
    .word      (word),
    .ser_out   (ser_out)
  );

  dacs_bank #(
    .CODE_W (CODE_W)
  ) i_bank (
    .clk      (clk),
    .rst_n    (dat_rst_n),
    .load_stb (pin_rise[P_FRAME]),
    .word     (word),
    .codes    (dac_codes),
    .asleep   (asleep)
  );

  // R10
  wipe_clear_chk: assert property (@(posedge clk)
    !wipe_n |-> (dac_codes == '0 && !asleep && !ser_out));

  // R1
  por_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (dac_codes == '0 && !asleep && !ser_out));
endmodule

// File: tb/test_octal_dac_front.sv
module test_octal_dac_front;
  localparam int CODE_W = 8;
  localparam int NCH    = 8;

  logic clk = 1'b0;
  logic rst_n, wipe_n, ser_clk, ser_in, frame_n;
  logic ser_out, asleep;
  logic [NCH*CODE_W-1:0] dac_codes;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0]       m_sh;
  logic [CODE_W-1:0] m_code [NCH];
  logic              m_sleep;

  always #4 clk = ~clk;

  octal_dac_front #(.CODE_W(CODE_W)) i_octal_dac_front (
    .clk(clk), .rst_n(rst_n), .wipe_n(wipe_n), .ser_clk(ser_clk),
    .ser_in(ser_in), .frame_n(frame_n), .ser_out(ser_out),
    .asleep(asleep), .dac_codes(dac_codes)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_for(input logic [3:0] a);
    if (a == 4'hE) return "R7";
    if (a == 4'hF) return "R5";
    if (a >= 4'h1 && a <= 4'h8) return "R4";
    return "R6";
  endfunction

  function automatic logic [15:0] mk_word(input logic [3:0] a,
                                          input logic [CODE_W-1:0] c);
    logic [15:0] w;
    w = 16'($urandom);
    w[15:12] = a;
    w[11 -: CODE_W] = c;
    return w;
  endfunction

  task automatic model_load(input logic [15:0] w);
    logic [3:0] a;
    logic [CODE_W-1:0] c;
    a = w[15:12];
    c = w[11 -: CODE_W];
    if (a >= 4'h1 && a <= 4'h8) m_code[a-1] = c;
    if (a == 4'hF) for (int k = 0; k < NCH; k++) m_code[k] = c;
    m_sleep = (a == 4'hE);
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NCH; k++)
      chk(dac_codes[k*CODE_W +: CODE_W] == m_code[k], req, $sformatf("ch%0d code", k),
          32'(dac_codes[k*CODE_W +: CODE_W]), 32'(m_code[k]));
    chk(asleep == m_sleep, (m_sleep ? "R7" : "R8"), "asleep",
        32'(asleep), 32'(m_sleep));
  endtask

  // R2 shifting, R9 delayed output; optional load at the end
  task automatic send_word(input logic [15:0] w, input bit do_load);
    frame_n = 1'b0;
    wait_clk(4);
    for (int i = 15; i >= 0; i--) begin
      ser_in = w[i];
      wait_clk(4);
      ser_clk = 1'b1;
      m_sh = {m_sh[14:0], w[i]};
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
      chk(ser_out == m_sh[15], "R9", "ser_out", 32'(ser_out), 32'(m_sh[15]));
    end
    if (do_load) begin
      frame_n = 1'b1;
      model_load(w);
      wait_clk(6);
      check_bank((w[15:12] == 4'hE) ? "R7" : tag_for(w[15:12]));
    end
  endtask

  initial begin
    wait_clk(150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wipe_n = 1'b1; ser_clk = 1'b0; ser_in = 1'b0; frame_n = 1'b1;
    m_sh = '0; m_sleep = 1'b0;
    for (int k = 0; k < NCH; k++) m_code[k] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    for (int k = 0; k < NCH; k++)
      chk(dac_codes[k*CODE_W +: CODE_W] == '0, "R1", "reset code",
          32'(dac_codes[k*CODE_W +: CODE_W]), 0);
    chk(asleep == 1'b0, "R1", "reset asleep", 32'(asleep), 0);
    chk(ser_out == 1'b0, "R1", "reset ser_out", 32'(ser_out), 0);

    // R4 each channel alone, R2 field layout
    for (int a = 1; a <= 8; a++) send_word(mk_word(4'(a), CODE_W'(a*29 + 3)), 1'b1);
    // R5 broadcast
    send_word(mk_word(4'hF, CODE_W'(8'hA5)), 1'b1);
    for (int a = 1; a <= 8; a++) send_word(mk_word(4'(a), CODE_W'(a*17)), 1'b1);
    // R6 no-change addresses
    send_word(mk_word(4'h0, '1), 1'b1);
    for (int a = 9; a <= 13; a++) send_word(mk_word(4'(a), '1), 1'b1);
    // R7 sleep, then R8 wake by no-change address
    send_word(mk_word(4'hE, '1), 1'b1);
    send_word(mk_word(4'h0, '0), 1'b1);
    // R7 sleep, then R8 wake with a channel load
    send_word(mk_word(4'hE, '0), 1'b1);
    send_word(mk_word(4'h3, CODE_W'(8'h3C)), 1'b1);

    // R3 serial clock with frame high is ignored
    ser_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0; wait_clk(4);
    end
    chk(ser_out == m_sh[15], "R3", "ser_out frame high", 32'(ser_out), 32'(m_sh[15]));
    send_word(mk_word(4'h5, CODE_W'(8'h11)), 1'b1);  // stream checks old word (R3)

    // chained words: only the last 16 bits load (R9 daisy)
    send_word(mk_word(4'h2, CODE_W'(8'hEE)), 1'b0);
    send_word(mk_word(4'h6, CODE_W'(8'h77)), 1'b1);

    // R10 wipe clears everything asynchronously
    send_word(mk_word(4'hE, '0), 1'b1);
    wipe_n = 1'b0;
    wait_clk(1);
    for (int k = 0; k < NCH; k++) m_code[k] = '0;
    m_sleep = 1'b0; m_sh = '0;
    chk(dac_codes == '0, "R10", "codes during wipe", 32'(dac_codes[31:0]), 0);
    chk(asleep == 1'b0, "R10", "asleep during wipe", 32'(asleep), 0);
    wait_clk(2);
    wipe_n = 1'b1;
    wait_clk(6);
    check_bank("R10");
    chk(ser_out == 1'b0, "R10", "ser_out after wipe", 32'(ser_out), 0);
    send_word(mk_word(4'h1, CODE_W'(8'h42)), 1'b1);  // stream of zeros (R10)

    // random traffic
    for (int n = 0; n < 150; n++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) a = 4'($urandom_range(1, 8));
      w = mk_word(a, CODE_W'($urandom));
      send_word(w, ($urandom_range(0, 4) != 0));
    end
    frame_n = 1'b1;
    model_load(m_sh);
    wait_clk(6);
    check_bank(tag_for(m_sh[15:12]));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule